// File: doc/BRIEF.md
# Periodic Comparator Event Timer

This block is an event timer addressed through a small 32-bit register bus. A single 64-bit counter advances by one on every clock while the global enable is on. A set of comparator channels watches that counter. When a channel's comparator equals the counter, the channel raises its interrupt line.

Channel 0 alone can run periodically. On each match it adds a stored period to its comparator, so it fires again one period later. The remaining channels fire once per match and leave their comparator alone.

Each 64-bit comparator is written as two 32-bit halves. On a periodic channel, a write lands on the comparator only while a per-channel load flag is armed, and the flag drops after every half written. Without the flag, the write updates only the period. Each interrupt line is active high. It is either a one-cycle pulse (edge style) or a sticky status bit that software clears (level style), and the level style lets several channels share one line.

Top module: `evt_timer`

## Requirements
- R1: The global enable (offset 0x04, bit 0) makes the counter step by exactly one per clock; while it is 0 the counter holds its value.
- R2: Writes to the counter halves (0x10 low, 0x14 high) take effect only while the global enable is 0 and are ignored while it is 1.
- R3: Channel n (config at 0x20+0x10*n) sees a match in any cycle where the global enable is 1 and the counter equals its comparator. Its interrupt goes high in the next cycle, and only if config bit 0 (interrupt enable) is 1. With either enable at 0, there is no interrupt and no status bit.
- R4: In edge style (config bit 1 = 0) a match drives the interrupt high for exactly one cycle, with no software action.
- R5: In level style (config bit 1 = 1) a match sets status bit n at 0x08, and the interrupt follows that bit until software writes 1 to it. A match in the same cycle as such a clearing write leaves the bit set.
- R6: Config bit 4 is a read-only periodic capability flag. It reads 1 on channel 0 only. The periodic type bit (config bit 2) can be set only on channel 0 and reads 0 on every other channel.
- R7: In periodic mode, a match adds the stored period to the comparator in the same cycle, so successive interrupts are exactly one period apart.
- R8: Comparator halves sit at channel base +0x08 (low) and +0x0C (high). With the load flag (config bit 3) set, or on a channel not in periodic mode, a half write loads the comparator and the period together. Any comparator half write clears the flag.
- R9: On a channel in periodic mode with the load flag at 0, a comparator half write changes only the period, and the comparator reads back unchanged.
- R10: A one-shot channel leaves its comparator unchanged after a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NUM_CH | Active-high interrupt per channel |

## Verification
A match that sets a level-style status bit can fall in the same cycle as software's write-1-to-clear of that bit. The bench provokes this by making the comparator equal the preloaded counter value. It then issues the clearing write immediately after the enable write, so the clear lands on exactly the clock edge of the match. The bench judges the result by the interrupt staying high and the status bit reading 1 afterwards.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int DW = 32;
  localparam int CW = 2 * DW;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_CTRL   = 8'h04;
  localparam logic [AW-1:0] A_STS    = 8'h08;
  localparam logic [AW-1:0] A_CNT_LO = 8'h10;
  localparam logic [AW-1:0] A_CNT_HI = 8'h14;

  localparam int CH_BASE   = 32;
  localparam int CH_STRIDE = 16;
  localparam int OFS_CFG   = 0;
  localparam int OFS_LO    = 8;
  localparam int OFS_HI    = 12;

  localparam int B_IEN = 0;
  localparam int B_LVL = 1;
  localparam int B_PER = 2;
  localparam int B_ARM = 3;
  localparam int B_CAP = 4;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
  import evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          lo_wr_i,
  input  logic          hi_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      if (lo_wr_i) cnt_d[DW-1:0]  = wdata_i;
      if (hi_wr_i) cnt_d[CW-1:DW] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> cnt_q == $past(cnt_q) + CW'(1));

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !lo_wr_i && !hi_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter bit CAN_PERIODIC = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          gen_en_i,
  input  logic          cfg_wr_i,
  input  logic          lo_wr_i,
  input  logic          hi_wr_i,
  input  logic          sts_clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o,
  output logic [CW-1:0] cmp_o,
  output logic          sts_o,
  output logic          irq_o
);
  logic          ien_q, lvl_q, per_q, arm_q, edge_q, sts_q;
  logic          ien_d, lvl_d, per_d, arm_d, edge_d, sts_d;
  logic [CW-1:0] cmp_q, cmp_d, prd_q, prd_d;
  logic          hit, direct, cmp_wr;

  assign hit    = gen_en_i && (cnt_i == cmp_q);
  assign direct = arm_q || !per_q;
  assign cmp_wr = lo_wr_i || hi_wr_i;

  always_comb begin
    ien_d = ien_q;
    lvl_d = lvl_q;
    per_d = per_q;
    arm_d = arm_q;
    if (cfg_wr_i) begin
      ien_d = wdata_i[B_IEN];
      lvl_d = wdata_i[B_LVL];
      per_d = wdata_i[B_PER] & CAN_PERIODIC;
      arm_d = wdata_i[B_ARM];
    end else if (cmp_wr) begin
      arm_d = 1'b0;
    end
  end

  always_comb begin
    cmp_d = cmp_q;
    prd_d = prd_q;
    if (cmp_wr) begin
      if (lo_wr_i) begin
        prd_d[DW-1:0] = wdata_i;
        if (direct) cmp_d[DW-1:0] = wdata_i;
      end
      if (hi_wr_i) begin
        prd_d[CW-1:DW] = wdata_i;
        if (direct) cmp_d[CW-1:DW] = wdata_i;
      end
    end else if (hit && per_q) begin
      cmp_d = cmp_q + prd_q;
    end
  end

  assign edge_d = hit && ien_q && !lvl_q;
  assign sts_d  = (sts_q && !sts_clr_i) || (hit && ien_q && lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      lvl_q  <= 1'b0;
      per_q  <= 1'b0;
      arm_q  <= 1'b0;
      edge_q <= 1'b0;
      sts_q  <= 1'b0;
      cmp_q  <= '0;
      prd_q  <= '0;
    end else begin
      ien_q  <= ien_d;
      lvl_q  <= lvl_d;
      per_q  <= per_d;
      arm_q  <= arm_d;
      edge_q <= edge_d;
      sts_q  <= sts_d;
      cmp_q  <= cmp_d;
      prd_q  <= prd_d;
    end
  end

  always_comb begin
    cfg_o        = '0;
    cfg_o[B_IEN] = ien_q;
    cfg_o[B_LVL] = lvl_q;
    cfg_o[B_PER] = per_q;
    cfg_o[B_ARM] = arm_q;
    cfg_o[B_CAP] = CAN_PERIODIC;
  end

  assign cmp_o = cmp_q;
  assign sts_o = sts_q;
  assign irq_o = lvl_q ? sts_q : edge_q;

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_q && !cmp_wr) |=> cmp_q == $past(cmp_q) + $past(prd_q));

  assert_oneshot_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !per_q && !cmp_wr) |=> $stable(cmp_q));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !cfg_wr_i) |=> !arm_q);

  assert_sts_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(lvl_q && ien_q && gen_en_i));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !sts_clr_i) |=> sts_q);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int TOP_ADDR = CH_BASE + NUM_CH * CH_STRIDE;

  logic [1:0]          rsync_q;
  logic                rst_sn;
  logic                en_q, en_d;
  logic [CW-1:0]       cnt;
  logic [DW-1:0]       cfg_rd [NUM_CH];
  logic [CW-1:0]       cmp_rd [NUM_CH];
  logic [NUM_CH-1:0]   sts;
  logic [NUM_CH-1:0]   sts_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  assign en_d = (bus_wr && bus_addr == A_CTRL) ? bus_wdata[0] : en_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  evt_counter i_cnt (
    .clk     (clk),
    .rst_n   (rst_sn),
    .en_i    (en_q),
    .lo_wr_i (bus_wr && bus_addr == A_CNT_LO),
    .hi_wr_i (bus_wr && bus_addr == A_CNT_HI),
    .wdata_i (bus_wdata),
    .cnt_o   (cnt)
  );

  assign sts_clr = (bus_wr && bus_addr == A_STS) ? bus_wdata[NUM_CH-1:0] : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = CH_BASE + g * CH_STRIDE;
    evt_channel #(.CAN_PERIODIC(g == 0)) i_ch (
      .clk       (clk),
      .rst_n     (rst_sn),
      .cnt_i     (cnt),
      .gen_en_i  (en_q),
      .cfg_wr_i  (bus_wr && bus_addr == AW'(BASE + OFS_CFG)),
      .lo_wr_i   (bus_wr && bus_addr == AW'(BASE + OFS_LO)),
      .hi_wr_i   (bus_wr && bus_addr == AW'(BASE + OFS_HI)),
      .sts_clr_i (sts_clr[g]),
      .wdata_i   (bus_wdata),
      .cfg_o     (cfg_rd[g]),
      .cmp_o     (cmp_rd[g]),
      .sts_o     (sts[g]),
      .irq_o     (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = {{(DW-1){1'b0}}, en_q};
      A_STS:    bus_rdata = DW'(sts);
      A_CNT_LO: bus_rdata = cnt[DW-1:0];
      A_CNT_HI: bus_rdata = cnt[CW-1:DW];
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (int'(bus_addr) == CH_BASE + i * CH_STRIDE + OFS_CFG) bus_rdata = cfg_rd[i];
          if (int'(bus_addr) == CH_BASE + i * CH_STRIDE + OFS_LO)  bus_rdata = cmp_rd[i][DW-1:0];
          if (int'(bus_addr) == CH_BASE + i * CH_STRIDE + OFS_HI)  bus_rdata = cmp_rd[i][CW-1:DW];
        end
      end
    endcase
  end

  initial begin
    assert_map_fits_R6: assert (TOP_ADDR <= (1 << AW) && NUM_CH >= 1 && NUM_CH <= DW);
  end

  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(!en_q) && !en_q && $stable(sts)) |-> ($countones(irq) <= $countones(sts)));
endmodule

// File: tb/test_evt_timer.sv
`timescale 1ns/100ps
module test_evt_timer;
  localparam int NCH = 3;
  localparam logic [7:0] CFG0 = 8'h20, LO0 = 8'h28, HI0 = 8'h2C;
  localparam logic [7:0] CFG1 = 8'h30, LO1 = 8'h38, HI1 = 8'h3C;

  typedef struct packed {
    logic [63:0] s;
    logic [63:0] c;
    logic [31:0] d;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{s: 64'd5, c: 64'd5, d: 32'd2},
    '{s: 64'd0, c: 64'd20, d: 32'd22},
    '{s: 64'hFFFF_FFFF_FFFF_FFFE, c: 64'd1, d: 32'd5},
    '{s: 64'h0000_0000_FFFF_FFFD, c: 64'h0000_0001_0000_0001, d: 32'd6}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  evt_timer #(.NUM_CH(NCH)) i_evt_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(input int ch, input int lim, output int n);
    n = -1;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (irq[ch]) begin n = k; break; end
    end
  endtask

  task automatic set_cnt(input logic [63:0] v);
    wr(8'h04, 0);
    wr(8'h10, v[31:0]);
    wr(8'h14, v[63:32]);
  endtask

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(8'h04, r); check(r == 0, "R1 reset enable", r, 0);
    rd(8'h10, r); check(r == 0, "R1 reset counter", r, 0);
    check(irq == 0, "R3 reset irq", irq, 0);
    rd(CFG0, r); check(r == 32'h10, "R6 ch0 capability", r, 32'h10);

    // R1 hold and step
    set_cnt(64'd100);
    repeat (5) @(negedge clk);
    rd(8'h10, r); check(r == 100, "R1 hold while disabled", r, 100);
    wr(8'h04, 1);
    repeat (9) @(negedge clk);
    wr(8'h04, 0);
    rd(8'h10, r); check(r == 110, "R1 step count", r, 110);
    // R2 write ignored while enabled
    wr(8'h04, 1);
    wr(8'h10, 0);
    wr(8'h04, 0);
    rd(8'h10, r); check(r == 112, "R2 counter write ignored", r, 112);

    // R3/R4/R10 one-shot vector table on channel 1
    foreach (VECS[i]) begin
      set_cnt(VECS[i].s);
      wr(CFG1, 32'h1);
      wr(LO1, VECS[i].c[31:0]);
      wr(HI1, VECS[i].c[63:32]);
      wr(8'h04, 1);
      wait_irq(1, 40, n);
      check(n == int'(VECS[i].d), "R3 match delay", n, VECS[i].d);
      @(negedge clk);
      check(irq[1] == 1'b0, "R4 one-cycle pulse", irq[1], 0);
      rd(LO1, r); check(r == VECS[i].c[31:0], "R10 comparator kept", r, VECS[i].c[31:0]);
      rd(8'h08, r); check(r == 0, "R4 no status in edge style", r, 0);
    end

    // R6 type bit not settable on channel 1
    wr(CFG1, 32'h4);
    rd(CFG1, r); check(r == 0, "R6 ch1 no periodic", r, 0);

    // R8/R9/R7 periodic channel 0
    set_cnt(64'd0);
    wr(CFG0, 32'hD);
    wr(LO0, 32'd3);
    rd(CFG0, r); check(r[3] == 1'b0, "R8 flag self-clears", r[3], 0);
    wr(CFG0, 32'hD);
    wr(HI0, 32'd0);
    wr(LO0, 32'd5);
    rd(LO0, r); check(r == 3, "R9 unarmed write keeps comparator", r, 3);
    rd(HI0, r); check(r == 0, "R8 armed high write", r, 0);
    wr(8'h04, 1);
    wait_irq(0, 40, n); check(n == 5, "R7 first periodic match", n, 5);
    wait_irq(0, 40, n); check(n == 5, "R7 period gap", n, 5);
    wait_irq(0, 40, n); check(n == 5, "R9 period from unarmed write", n, 5);
    wr(8'h04, 0);
    rd(LO0, r); check(r == 18, "R7 comparator advanced", r, 18);
    wr(CFG0, 0);

    // R5 level style
    set_cnt(64'd0);
    wr(8'h08, 32'h7);
    wr(CFG1, 32'h3);
    wr(LO1, 32'd3);
    wr(HI1, 32'd0);
    wr(8'h04, 1);
    wait_irq(1, 40, n); check(n == 5, "R3 level match delay", n, 5);
    repeat (3) @(negedge clk);
    check(irq[1] == 1'b1, "R5 level held", irq[1], 1);
    rd(8'h08, r); check(r == 32'h2, "R5 status bit", r, 2);
    wr(8'h08, 32'h2);
    @(negedge clk);
    check(irq[1] == 1'b0, "R5 cleared by write", irq[1], 0);

    // R5 collision: clear lands on the match edge
    set_cnt(64'd10);
    wr(LO1, 32'd10);
    wr(8'h04, 1);
    wr(8'h08, 32'h2);
    @(negedge clk);
    check(irq[1] == 1'b1, "R5 set wins over clear", irq[1], 1);
    rd(8'h08, r); check(r == 32'h2, "R5 status after collision", r, 2);
    wr(8'h08, 32'h2);

    // R3 channel interrupt enable off
    set_cnt(64'd0);
    wr(CFG1, 32'h2);
    wr(LO1, 32'd2);
    wr(8'h04, 1);
    repeat (8) @(negedge clk);
    check(irq[1] == 1'b0, "R3 channel disabled no irq", irq[1], 0);
    rd(8'h08, r); check(r == 0, "R3 channel disabled no status", r, 0);

    // R3 global enable off
    set_cnt(64'd7);
    wr(CFG1, 32'h3);
    wr(LO1, 32'd7);
    repeat (8) @(negedge clk);
    check(irq[1] == 1'b0, "R3 global disabled no irq", irq[1], 0);
    rd(8'h10, r); check(r == 7, "R1 counter held", r, 7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule